// File: doc/BRIEF.md
# Repeater Port Partition Controller

This block watches every port of a multiport Ethernet repeater and cuts off (partitions) any port that keeps colliding. It does this for a parameterized number of twisted-pair ports plus one attachment-unit port. A port is flagged for partition in two cases: it takes part in a run of consecutive collisions, or a single collision on it goes on too long. A partitioned port does not have its receive activity forwarded. The controller still watches that port, so that it can bring the port back when traffic on it is healthy again.

A port is brought back after a collision-free packet that is longer than a reconnection threshold, counted in bit-time strobes. Two reconnection algorithms are available. The standard one accepts a packet in either direction. The alternative one accepts only a packet that the port itself transmitted. All twisted-pair ports follow one shared algorithm select. The attachment-unit port, which is the highest port index, follows its own select. A port that is disabled loses its partition state and all of its history.

Top module: `rpt_part_ctl`

## Requirements
- R1: `col_o[i]` is high exactly while port i is enabled and both `tx_act_i[i]` and `rx_act_i[i]` are high (combinational).
- R2: A collision event is a cycle where the collision condition rises. When the COL_LIMIT-th (default 32) event arrives without a clean packet in between, `part_o[i]` goes high in the next cycle.
- R3: One continuous collision that sees more than LONG_COL (default 1024) bit-time strobes partitions the port in the cycle after the strobe that passes the limit. Exactly LONG_COL strobes does not partition.
- R4: A packet that ends with no collision resets the consecutive collision-event count to zero.
- R5: A packet is a run of cycles with `tx_act_i|rx_act_i` high. Its length is the number of `bit_tick_i` strobes seen during that run. With the standard algorithm (select bit 0), a partitioned port clears `part_o` in the cycle after the first idle cycle that ends a collision-free packet longer than RECON_LEN (default 512). The packet may be transmitted or received.
- R6: A packet of RECON_LEN strobes or fewer, or a packet that has a collision anywhere in it, leaves a partitioned port partitioned.
- R7: With the alternative algorithm (select bit 1), only a qualifying packet that has no receive activity at any point reconnects. A qualifying received packet is ignored: `part_o` stays high.
- R8: When `cfg_we_i` is high, `tp_alt_i` and `aui_alt_i` are loaded. The `tp_alt_i` value governs every twisted-pair port (indices 0..N_TP-1), and the `aui_alt_i` value governs only port N_TP.
- R9: During reset and after it, `part_o` is all zero and both algorithm selects are at the standard algorithm.
- R10: While `port_en_i[i]` is low, `part_o[i]`, `col_o[i]` and `rx_fwd_o[i]` are low and the port's inputs are ignored. Partition state and all counters are cleared, so a port that is enabled again starts with no collision history.
- R11: `rx_fwd_o[i]` is high exactly when port i is enabled, not partitioned, and `rx_act_i[i]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Load strobe for the algorithm selects |
| tp_alt_i | input | 1 | Twisted-pair algorithm select, 1 = alternative |
| aui_alt_i | input | 1 | Attachment-unit algorithm select, 1 = alternative |
| port_en_i | input | N_TP+1 | Per-port enable |
| bit_tick_i | input | N_TP+1 | Per-port bit-time strobe |
| tx_act_i | input | N_TP+1 | Per-port transmit activity |
| rx_act_i | input | N_TP+1 | Per-port receive activity |
| part_o | output | N_TP+1 | Per-port partitioned flag |
| col_o | output | N_TP+1 | Per-port collision indication |
| rx_fwd_o | output | N_TP+1 | Per-port receive activity allowed to be forwarded |

## Verification
The bench attacks the off-by-one edges. It uses runs of 31 collision events against 32, collisions of exactly 1024 strobes against 1025, and packets of exactly 512 strobes against 513. A design with a misplaced comparison would partition early or reconnect on a packet that is too short. It also sends a clean short packet between two runs of 31 collisions. A design that did not clear its count would partition there. Received packets are sent while the alternative algorithm is selected, and the two select domains are set to opposite values. A design that read the wrong select would reconnect the wrong port. Disable and re-enable checks that stale collision counts do not survive. A packet with sparse strobes checks that length is measured in strobes, not in clock cycles.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  typedef struct packed {
    logic tp_alt;
    logic aui_alt;
  } rpc_cfg_t;

  localparam rpc_cfg_t RPC_CFG_RST = '{tp_alt: 1'b0, aui_alt: 1'b0};
endpackage

// File: rtl/rpc_cfg.sv
module rpc_cfg
  import rpc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  rpc_cfg_t cfg_i,
  output rpc_cfg_t cfg_o
);
  rpc_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= RPC_CFG_RST;
    else if (we_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/rpc_col_mon.sv
module rpc_col_mon #(
  parameter int COL_LIMIT = 32,
  parameter int LONG_COL  = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic col_i,
  input  logic clr_cnt_i,
  output logic part_set_o
);
  localparam int CW = $clog2(COL_LIMIT + 1);
  localparam int LW = $clog2(LONG_COL + 2);
  localparam logic [CW-1:0] CNT_MAX  = CW'(COL_LIMIT);
  localparam logic [CW-1:0] CNT_TRIP = CW'(COL_LIMIT - 1);
  localparam logic [LW-1:0] LEN_MAX  = LW'(LONG_COL + 1);
  localparam logic [LW-1:0] LEN_TRIP = LW'(LONG_COL);

  logic          col_q;
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] len_q;
  logic          rise;

  assign rise = col_i & ~col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= 1'b0;
      cnt_q <= '0;
      len_q <= '0;
    end else if (!en_i) begin
      col_q <= 1'b0;
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      col_q <= col_i;
      if (clr_cnt_i)                    cnt_q <= '0;
      else if (rise && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (!col_i)                          len_q <= '0;
      else if (tick_i && len_q != LEN_MAX) len_q <= len_q + 1'b1;
    end
  end

  // trip on the event that completes the run, or the strobe that passes the limit
  assign part_set_o = en_i & ((rise & (cnt_q >= CNT_TRIP)) |
                              (col_i & tick_i & (len_q == LEN_TRIP)));
endmodule

// File: rtl/rpc_pkt_mon.sv
module rpc_pkt_mon #(
  parameter int RECON_LEN = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic tx_i,
  input  logic rx_i,
  input  logic part_i,
  input  logic alt_i,
  output logic clean_end_o,
  output logic recon_o
);
  localparam int PW = $clog2(RECON_LEN + 2);
  localparam logic [PW-1:0] LEN_MAX = PW'(RECON_LEN + 1);

  logic          act, col;
  logic          in_pkt_q, pcol_q, prx_q;
  logic [PW-1:0] len_q;

  assign act = tx_i | rx_i;
  assign col = tx_i & rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q <= 1'b0;
      pcol_q   <= 1'b0;
      prx_q    <= 1'b0;
      len_q    <= '0;
    end else if (!en_i) begin
      in_pkt_q <= 1'b0;
      pcol_q   <= 1'b0;
      prx_q    <= 1'b0;
      len_q    <= '0;
    end else if (act) begin
      if (!in_pkt_q) begin
        in_pkt_q <= 1'b1;
        len_q    <= {{(PW-1){1'b0}}, tick_i};
        pcol_q   <= col;
        prx_q    <= rx_i;
      end else begin
        if (tick_i && len_q != LEN_MAX) len_q <= len_q + 1'b1;
        pcol_q <= pcol_q | col;
        prx_q  <= prx_q | rx_i;
      end
    end else begin
      in_pkt_q <= 1'b0;
    end
  end

  assign clean_end_o = en_i & in_pkt_q & ~act & ~pcol_q;
  assign recon_o     = clean_end_o & part_i & (len_q == LEN_MAX) & (~alt_i | ~prx_q);
endmodule

// File: rtl/rpt_part_ctl.sv
module rpt_part_ctl
  import rpc_pkg::*;
#(
  parameter int N_TP      = 4,
  parameter int COL_LIMIT = 32,
  parameter int LONG_COL  = 1024,
  parameter int RECON_LEN = 512,
  localparam int NP       = N_TP + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          tp_alt_i,
  input  logic          aui_alt_i,
  input  logic [NP-1:0] port_en_i,
  input  logic [NP-1:0] bit_tick_i,
  input  logic [NP-1:0] tx_act_i,
  input  logic [NP-1:0] rx_act_i,
  output logic [NP-1:0] part_o,
  output logic [NP-1:0] col_o,
  output logic [NP-1:0] rx_fwd_o
);
  rpc_cfg_t cfg_d, cfg_q;

  assign cfg_d = '{tp_alt: tp_alt_i, aui_alt: aui_alt_i};

  rpc_cfg u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .cfg_i (cfg_d),
    .cfg_o (cfg_q)
  );

  for (genvar i = 0; i < NP; i++) begin : g_port
    logic alt, col, part_q, part_set, clean_end, recon;

    if (i == N_TP) begin : g_aui
      assign alt = cfg_q.aui_alt;
    end else begin : g_tp
      assign alt = cfg_q.tp_alt;
    end

    assign col = tx_act_i[i] & rx_act_i[i];

    rpc_col_mon #(.COL_LIMIT(COL_LIMIT), .LONG_COL(LONG_COL)) u_col (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (port_en_i[i]),
      .tick_i    (bit_tick_i[i]),
      .col_i     (col),
      .clr_cnt_i (clean_end),
      .part_set_o(part_set)
    );

    rpc_pkt_mon #(.RECON_LEN(RECON_LEN)) u_pkt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (port_en_i[i]),
      .tick_i     (bit_tick_i[i]),
      .tx_i       (tx_act_i[i]),
      .rx_i       (rx_act_i[i]),
      .part_i     (part_q),
      .alt_i      (alt),
      .clean_end_o(clean_end),
      .recon_o    (recon)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           part_q <= 1'b0;
      else if (!port_en_i[i]) part_q <= 1'b0;
      else if (part_set)     part_q <= 1'b1;
      else if (recon)        part_q <= 1'b0;
    end

    assign part_o[i]   = part_q & port_en_i[i];
    assign col_o[i]    = col & port_en_i[i];
    assign rx_fwd_o[i] = rx_act_i[i] & port_en_i[i] & ~part_q;
  end
endmodule

// File: rtl/rpt_part_ctl_chk.sv
module rpt_part_ctl_chk #(
  parameter int NP = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NP-1:0] port_en_i,
  input logic [NP-1:0] tx_act_i,
  input logic [NP-1:0] rx_act_i,
  input logic [NP-1:0] part_o,
  input logic [NP-1:0] col_o,
  input logic [NP-1:0] rx_fwd_o
);
  for (genvar i = 0; i < NP; i++) begin : g_chk
    a_r10_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !port_en_i[i] |-> (!part_o[i] && !col_o[i] && !rx_fwd_o[i]));

    a_r11_no_fwd_when_part: assert property (@(posedge clk_i) disable iff (!rst_ni)
      part_o[i] |-> !rx_fwd_o[i]);

    // R2, R3: partition only follows a cycle with a collision on the port
    a_r2_part_after_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(part_o[i]) |-> $past(tx_act_i[i] && rx_act_i[i]));

    // R5: reconnection only after the port went idle, or by disabling it
    a_r5_recon_on_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(part_o[i]) |-> (!port_en_i[i] || !$past(tx_act_i[i] || rx_act_i[i])));

    a_r1_col_needs_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
      col_o[i] |-> (tx_act_i[i] && rx_act_i[i]));
  end
endmodule

bind rpt_part_ctl rpt_part_ctl_chk #(.NP(NP)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .port_en_i(port_en_i),
  .tx_act_i (tx_act_i),
  .rx_act_i (rx_act_i),
  .part_o   (part_o),
  .col_o    (col_o),
  .rx_fwd_o (rx_fwd_o)
);

// File: tb/rpt_part_ctl_tb.sv
`timescale 1ns/1ps
module rpt_part_ctl_tb;
  localparam int N_TP = 4;
  localparam int NP = N_TP + 1;
  localparam int COLL = 32;
  localparam int LCOL = 1024;
  localparam int RLEN = 512;
  localparam int AUI = N_TP;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we = 1'b0, tp_alt = 1'b0, aui_alt = 1'b0;
  logic [NP-1:0] en_v = '1, tick_v = '1, tx_v = '0, rx_v = '0;
  logic [NP-1:0] part_o, col_o, rx_fwd_o;
  bit half_rate = 1'b0;
  int checks = 0, errors = 0;

  // reference model state
  int m_part[NP], m_inpkt[NP], m_len[NP], m_pcol[NP], m_prx[NP];
  int m_ccnt[NP], m_clen[NP], m_colq[NP];
  int m_tpalt = 0, m_aualt = 0;

  always #2 clk = ~clk;

  rpt_part_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .tp_alt_i(tp_alt),
    .aui_alt_i(aui_alt), .port_en_i(en_v), .bit_tick_i(tick_v),
    .tx_act_i(tx_v), .rx_act_i(rx_v), .part_o(part_o), .col_o(col_o),
    .rx_fwd_o(rx_fwd_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) tick_v <= half_rate ? ~tick_v : '1;

  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int p = 0; p < NP; p++) begin
        m_part[p] = 0; m_inpkt[p] = 0; m_len[p] = 0; m_pcol[p] = 0;
        m_prx[p] = 0; m_ccnt[p] = 0; m_clen[p] = 0; m_colq[p] = 0;
      end
      m_tpalt = 0; m_aualt = 0;
    end else begin
      for (int p = 0; p < NP; p++) begin
        int act, col, alt, np;
        if (!en_v[p]) begin
          m_part[p] = 0; m_inpkt[p] = 0; m_len[p] = 0; m_pcol[p] = 0;
          m_prx[p] = 0; m_ccnt[p] = 0; m_clen[p] = 0; m_colq[p] = 0;
          continue;
        end
        act = tx_v[p] | rx_v[p];
        col = tx_v[p] & rx_v[p];
        alt = (p == AUI) ? m_aualt : m_tpalt;
        np = m_part[p];
        if (col && !m_colq[p]) begin
          if (m_ccnt[p] + 1 >= COLL) np = 1;
          if (m_ccnt[p] < COLL) m_ccnt[p]++;
        end
        if (!col) m_clen[p] = 0;
        else if (tick_v[p]) begin
          m_clen[p]++;
          if (m_clen[p] == LCOL + 1) np = 1;
        end
        if (act) begin
          if (!m_inpkt[p]) begin
            m_inpkt[p] = 1; m_len[p] = tick_v[p]; m_pcol[p] = col; m_prx[p] = rx_v[p];
          end else begin
            m_len[p] += tick_v[p];
            m_pcol[p] |= col; m_prx[p] |= rx_v[p];
          end
        end else if (m_inpkt[p]) begin
          m_inpkt[p] = 0;
          if (!m_pcol[p]) begin
            m_ccnt[p] = 0;
            if (m_part[p] && m_len[p] > RLEN && (!alt || !m_prx[p])) np = 0;
          end
        end
        m_colq[p] = col;
        m_part[p] = np;
      end
      if (cfg_we) begin m_tpalt = tp_alt; m_aualt = aui_alt; end
    end
    #1;
    if (rst_ni) begin
      for (int p = 0; p < NP; p++) begin
        chk(part_o[p], logic'(m_part[p] != 0 && en_v[p]), "R5 model part_o");
        chk(col_o[p], tx_v[p] & rx_v[p] & en_v[p], "R1 model col_o");
        chk(rx_fwd_o[p], logic'(rx_v[p] && en_v[p] && m_part[p] == 0), "R11 model rx_fwd_o");
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic coll_pkt(input int p);
    @(negedge clk); tx_v[p] = 1'b1; rx_v[p] = 1'b1;
    idle(3);
    tx_v[p] = 1'b0; rx_v[p] = 1'b0;
    idle(2);
  endtask

  task automatic tx_pkt(input int p, input int n);
    @(negedge clk); tx_v[p] = 1'b1;
    idle(n);
    tx_v[p] = 1'b0;
    idle(2);
  endtask

  task automatic rx_pkt(input int p, input int n);
    @(negedge clk); rx_v[p] = 1'b1;
    idle(n);
    rx_v[p] = 1'b0;
    idle(2);
  endtask

  task automatic long_coll(input int p, input int n);
    @(negedge clk); tx_v[p] = 1'b1; rx_v[p] = 1'b1;
    idle(n);
    tx_v[p] = 1'b0; rx_v[p] = 1'b0;
    idle(2);
  endtask

  task automatic cfg(input logic t, input logic a);
    @(negedge clk); cfg_we = 1'b1; tp_alt = t; aui_alt = a;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    chk(|part_o, 1'b0, "R9 part_o in reset");
    @(negedge clk); rst_ni = 1'b1;
    idle(2);
    chk(|part_o, 1'b0, "R9 part_o after reset");

    // R4: clean packet clears the run
    repeat (COLL - 1) coll_pkt(0);
    chk(part_o[0], 1'b0, "R2 31 events");
    tx_pkt(0, 10);
    repeat (COLL - 1) coll_pkt(0);
    chk(part_o[0], 1'b0, "R4 count cleared by clean packet");
    coll_pkt(0);
    chk(part_o[0], 1'b1, "R2 32nd event partitions");
    @(negedge clk); rx_v[0] = 1'b1; @(posedge clk); #1;
    chk(rx_fwd_o[0], 1'b0, "R11 no forward while partitioned");
    chk(rx_fwd_o[1], 1'b0, "R11 idle port");
    idle(1); rx_v[0] = 1'b0; idle(2);

    // R5/R6 with standard algorithm (R9 default)
    half_rate = 1'b1;
    rx_pkt(0, 700);
    half_rate = 1'b0;
    chk(part_o[0], 1'b1, "R5 sparse strobes counted");
    rx_pkt(0, RLEN);
    chk(part_o[0], 1'b1, "R6 exactly 512 strobes");
    @(negedge clk); rx_v[0] = 1'b1;
    idle(200); tx_v[0] = 1'b1; idle(1); tx_v[0] = 1'b0;
    idle(400); rx_v[0] = 1'b0; idle(2);
    chk(part_o[0], 1'b1, "R6 collided packet");
    rx_pkt(0, RLEN + 1);
    chk(part_o[0], 1'b0, "R5 513 received strobes reconnect");

    // R3 long collision
    long_coll(1, LCOL);
    chk(part_o[1], 1'b0, "R3 exactly 1024 strobes");
    long_coll(1, LCOL + 1);
    chk(part_o[1], 1'b1, "R3 1025 strobes partition");

    // R10 disable
    @(negedge clk); en_v[1] = 1'b0; tx_v[1] = 1'b1; rx_v[1] = 1'b1;
    @(posedge clk); #1;
    chk(part_o[1], 1'b0, "R10 disabled part_o");
    chk(col_o[1], 1'b0, "R10 disabled col_o");
    idle(2); tx_v[1] = 1'b0; rx_v[1] = 1'b0; en_v[1] = 1'b1; idle(2);
    chk(part_o[1], 1'b0, "R10 re-enabled clear");
    repeat (20) coll_pkt(0);
    @(negedge clk); en_v[0] = 1'b0; idle(2); en_v[0] = 1'b1; idle(1);
    repeat (20) coll_pkt(0);
    chk(part_o[0], 1'b0, "R10 count cleared by disable");
    tx_pkt(0, 5);

    // R7/R8: TP alternative, AUI standard
    cfg(1'b1, 1'b0);
    repeat (COLL) coll_pkt(2);
    repeat (COLL) coll_pkt(AUI);
    chk(part_o[2], 1'b1, "R2 port2 partitioned");
    chk(part_o[AUI], 1'b1, "R2 aui partitioned");
    rx_pkt(2, 600);
    chk(part_o[2], 1'b1, "R7 received packet ignored");
    tx_pkt(2, 600);
    chk(part_o[2], 1'b0, "R7 transmitted packet reconnects");
    rx_pkt(AUI, 600);
    chk(part_o[AUI], 1'b0, "R8 aui standard while tp alternative");

    // R8: opposite setting
    cfg(1'b0, 1'b1);
    repeat (COLL) coll_pkt(3);
    repeat (COLL) coll_pkt(AUI);
    rx_pkt(3, 600);
    chk(part_o[3], 1'b0, "R8 tp standard received reconnects");
    rx_pkt(AUI, 600);
    chk(part_o[AUI], 1'b1, "R8 aui alternative ignores received");
    tx_pkt(AUI, 600);
    chk(part_o[AUI], 1'b0, "R7 aui transmitted reconnects");

    @(negedge clk); tx_v[4] = 1'b1; rx_v[4] = 1'b1; @(posedge clk); #1;
    chk(col_o[4], 1'b1, "R1 collision shown");
    idle(1); tx_v[4] = 1'b0; rx_v[4] = 1'b0; idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule